// File: doc/BRIEF.md
# A/D Acquisition Trigger and Interrupt Controller

This block sits between an 8-bit host bus and a 12-bit ADC core on a data-acquisition card. It has one control byte. The control byte selects how a conversion is started: a host write, an external trigger pulse, or a tick from an external pacer counter. The same byte also enables one of six interrupt lines and enables per-conversion DMA requests. The ADC core is driven through a start/done handshake. Each finished conversion is latched as a 16-bit word. The sample sits in the upper twelve bits and the channel number of the sample in the lower four, so the host can compare the channel against its scan list and detect dropped samples.

After a conversion finishes, a data-ready flag is set. If interrupts are enabled, the selected interrupt line is raised and held until the host writes the clear address. If DMA is enabled, a request is raised for every result and dropped on acknowledge. The status byte also reports a strap that gives the analog input configuration.

Top module: `adc_acq_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, the data-ready status bit is 0, and `irq_out`, `dma_req` and `adc_start` are all low.
- R2: With control bits [1:0] = 00 (software trigger), any write to address 0 produces a one-cycle `adc_start` pulse in the cycle after the write. With bits [1:0] = 01 no trigger source starts a conversion.
- R3: With bits [1:0] = 10, an `ext_trig` pulse starts a conversion. With bits [1:0] = 11, a `pacer_tick` pulse starts one. A trigger from a source that is not selected is ignored.
- R4: A trigger that arrives between `adc_start` and `adc_done` starts no further conversion.
- R5: On `adc_done`, the word {sample[11:0], channel[3:0]} is latched. Address 0 reads its low byte, {sample[3:0], channel}, and address 1 reads its high byte, sample[11:4].
- R6: Status byte at address 8: bit 4 is set when a conversion finishes, bit 5 mirrors `se_mode`, and all other bits read 0.
- R7: Any write to address 8 clears the data-ready bit and the pending interrupt in the following cycle.
- R8: With control bit 7 set and bits [6:4] = n with n in 2..7, a finished conversion raises `irq_out[n]` and only that bit, and holds it until it is cleared. With n = 0 or 1, no line is raised.
- R9: With control bit 2 set, each finished conversion raises `dma_req`, which stays high until `dma_ack`.
- R10: Writing the control byte with bit 7 clear drops any pending interrupt, and writing it with bit 2 clear drops any pending DMA request. Both writes keep the trigger source, so a control value masked with 0x73 halts interrupts and DMA while conversions still run. Writing 0x00 leaves only the software trigger active, so pacer and external pulses start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_addr | input | 4 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for `bus_addr` (combinational) |
| ext_trig | input | 1 | External conversion trigger pulse |
| pacer_tick | input | 1 | Pacer counter output pulse |
| se_mode | input | 1 | Input configuration strap: 1 = single-ended |
| adc_start | output | 1 | Conversion start pulse to the ADC core |
| adc_done | input | 1 | Conversion finished pulse from the ADC core |
| adc_sample | input | 12 | Conversion value, valid with `adc_done` |
| adc_chan | input | 4 | Channel of the conversion, valid with `adc_done` |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge |
| irq_out | output | 8 | Interrupt lines, one bit per line number |

## Verification
Each trigger is sampled at a clock edge and produces `adc_start` after that edge, so the bench counts start pulses at the falling edge one cycle after the trigger. A result, data-ready, interrupt or DMA request is due one edge after `adc_done`. The bench's ADC model raises `adc_done` three cycles after it sees the start, and the bench looks for the effects only after the following edge. A clear or control write takes effect one edge after the strobe. All bus reads are combinational, so they are sampled shortly after setting the address at a falling edge. Expected result words go into a queue when each conversion is issued and are popped when the result is read.

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl #(
  parameter int SAMPLE_W = 12,
  parameter int CHAN_W   = 4,
  parameter int ADDR_W   = 4,
  parameter int IRQ_N    = 8,
  parameter logic [ADDR_W-1:0] A_DLO  = 4'd0,
  parameter logic [ADDR_W-1:0] A_DHI  = 4'd1,
  parameter logic [ADDR_W-1:0] A_STAT = 4'd8,
  parameter logic [ADDR_W-1:0] A_CTRL = 4'd9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic                ext_trig,
  input  logic                pacer_tick,
  input  logic                se_mode,
  output logic                adc_start,
  input  logic                adc_done,
  input  logic [SAMPLE_W-1:0] adc_sample,
  input  logic [CHAN_W-1:0]   adc_chan,
  output logic                dma_req,
  input  logic                dma_ack,
  output logic [IRQ_N-1:0]    irq_out
);

  localparam int WORD_W = SAMPLE_W + CHAN_W;
  localparam int MIN_LINE = 2;

  logic [7:0]        ctrl;
  logic [WORD_W-1:0] result;
  logic              busy, drdy, irq_pend;

  wire [1:0] trig_sel = ctrl[1:0];
  wire       irq_en   = ctrl[7];
  wire       dma_en   = ctrl[2];
  wire [2:0] irq_line = ctrl[6:4];

  wire wr_dlo  = bus_wr && (bus_addr == A_DLO);
  wire wr_stat = bus_wr && (bus_addr == A_STAT);
  wire wr_ctrl = bus_wr && (bus_addr == A_CTRL);

  wire trig = (trig_sel == 2'b00 && wr_dlo)
           || (trig_sel == 2'b10 && ext_trig)
           || (trig_sel == 2'b11 && pacer_tick);
  wire launch = trig && !busy;
  wire fin    = adc_done && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      result    <= '0;
      busy      <= 1'b0;
      drdy      <= 1'b0;
      irq_pend  <= 1'b0;
      dma_req   <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata;
      adc_start <= launch;

      if (launch)   busy <= 1'b1;
      else if (fin) busy <= 1'b0;

      if (fin) result <= {adc_sample, adc_chan};

      if (fin)          drdy <= 1'b1;
      else if (wr_stat) drdy <= 1'b0;

      if (fin && irq_en)                                 irq_pend <= 1'b1;
      else if (wr_stat || (wr_ctrl && !bus_wdata[7]))    irq_pend <= 1'b0;

      if (fin && dma_en)                                 dma_req <= 1'b1;
      else if (dma_ack || (wr_ctrl && !bus_wdata[2]))    dma_req <= 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
      if (g < MIN_LINE) begin : g_none
        assign irq_out[g] = 1'b0;
      end else begin : g_line
        assign irq_out[g] = irq_en && irq_pend && (irq_line == 3'(g));
      end
    end
  endgenerate

  always_comb begin
    case (bus_addr)
      A_DLO:   bus_rdata = result[7:0];
      A_DHI:   bus_rdata = result[15:8];
      A_STAT:  bus_rdata = {2'b00, se_mode, drdy, 4'b0000};
      A_CTRL:  bus_rdata = ctrl;
      default: bus_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/adc_acq_ctrl_chk.sv
module adc_acq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [3:0] bus_addr,
  input logic       adc_start,
  input logic       adc_done,
  input logic       busy,
  input logic       drdy,
  input logic       dma_req,
  input logic       dma_ack,
  input logic [7:0] irq_out
);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R2

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adc_done) |=> !adc_start); // R4

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done && busy) |=> drdy); // R6

  AST_CLEAR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd8 && !adc_done) |=> (irq_out == 8'h00 && !drdy)); // R7

  AST_IRQ_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_out)); // R8

  AST_DMA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && !adc_done) |=> !dma_req); // R9

endmodule

bind adc_acq_ctrl adc_acq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .adc_start(adc_start), .adc_done(adc_done), .busy(busy), .drdy(drdy),
  .dma_req(dma_req), .dma_ack(dma_ack), .irq_out(irq_out)
);

// File: tb/adc_acq_ctrl_tb.sv
module adc_acq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ext_trig = 1'b0;
  logic        pacer_tick = 1'b0;
  logic        se_mode = 1'b1;
  logic        adc_start;
  logic        adc_done = 1'b0;
  logic [11:0] adc_sample = '0;
  logic [3:0]  adc_chan = '0;
  logic        dma_req;
  logic        dma_ack = 1'b0;
  logic [7:0]  irq_out;

  int checks = 0;
  int errors = 0;
  int nstart = 0;
  logic [11:0] m_sample = '0;
  logic [3:0]  m_chan = '0;
  logic [15:0] exp_q[$];
  localparam int LAT = 3;

  always #2 clk = ~clk;

  adc_acq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
    .pacer_tick(pacer_tick), .se_mode(se_mode), .adc_start(adc_start),
    .adc_done(adc_done), .adc_sample(adc_sample), .adc_chan(adc_chan),
    .dma_req(dma_req), .dma_ack(dma_ack), .irq_out(irq_out)
  );

  always @(posedge clk) if (rst_n && adc_start) nstart <= nstart + 1;

  initial begin
    forever begin
      @(negedge clk);
      adc_done = 1'b0;
      if (adc_start) begin
        repeat (LAT) @(negedge clk);
        adc_sample = m_sample;
        adc_chan   = m_chan;
        adc_done   = 1'b1;
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic pulse_pacer();
    @(negedge clk); pacer_tick = 1'b1;
    @(negedge clk); pacer_tick = 1'b0;
  endtask

  // kind: 0 soft, 1 external, 2 pacer; expects one start and a finished result
  task automatic run_conv(input int kind, input logic [11:0] s, input logic [3:0] c, input string req);
    int n0;
    n0 = nstart;
    m_sample = s; m_chan = c;
    exp_q.push_back({s, c});
    case (kind)
      0: wr(4'd0, 8'h00);
      1: pulse_ext();
      default: pulse_pacer();
    endcase
    repeat (LAT + 3) @(negedge clk);
    check(req, 16'(nstart - n0), 16'd1);
  endtask

  task automatic check_result(input string req);
    logic [7:0] lo, hi;
    logic [15:0] e;
    rd(4'd0, lo);
    rd(4'd1, hi);
    e = exp_q.pop_front();
    check(req, {hi, lo}, e);
  endtask

  initial begin
    repeat (400) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [7:0] d;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd9, d); check("R1 ctrl", 16'(d), 16'h00);
    rd(4'd8, d); check("R1 status ready", 16'(d[4]), 16'h0);
    check("R1 outputs", {6'b0, dma_req, adc_start, irq_out}, 16'h0);

    // R2 software trigger, R5 word layout, R6 status
    run_conv(0, 12'hABC, 4'h5, "R2 soft start");
    check_result("R5 result word");
    rd(4'd8, d); check("R6 status ready+se", 16'(d), 16'h30);
    check("R8 irq disabled", 16'(irq_out), 16'h0);

    // R7 clear
    wr(4'd8, 8'h00);
    rd(4'd8, d); check("R7 ready cleared", 16'(d), 16'h20);

    // R2 mode 01: nothing starts; R3 unselected external ignored
    wr(4'd9, 8'h01);
    n0 = nstart;
    wr(4'd0, 8'h00); pulse_ext(); pulse_pacer();
    repeat (2) @(negedge clk);
    check("R2 mode 01 no start", 16'(nstart - n0), 16'd0);

    // R3 external trigger, soft write ignored in this mode
    wr(4'd9, 8'h02);
    n0 = nstart;
    wr(4'd0, 8'h00); pulse_pacer();
    repeat (2) @(negedge clk);
    check("R3 unselected ignored", 16'(nstart - n0), 16'd0);
    run_conv(1, 12'h123, 4'hF, "R3 ext start");
    check_result("R5 ext result");

    // R3 pacer + R8 interrupt on line 3, held, R7 clears
    wr(4'd9, 8'hB3);
    run_conv(2, 12'h0F0, 4'h3, "R3 pacer start");
    check("R8 irq line 3", 16'(irq_out), 16'h08);
    repeat (5) @(negedge clk);
    check("R8 irq held", 16'(irq_out), 16'h08);
    check_result("R5 pacer result");
    wr(4'd8, 8'h00);
    check("R7 irq cleared", 16'(irq_out), 16'h00);

    // R4 triggers while busy ignored
    n0 = nstart;
    m_sample = 12'h555; m_chan = 4'h1;
    exp_q.push_back({12'h555, 4'h1});
    @(negedge clk); pacer_tick = 1'b1;
    repeat (3) @(negedge clk);
    pacer_tick = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    check("R4 busy ignored", 16'(nstart - n0), 16'd1);
    check_result("R4 result");
    wr(4'd8, 8'h00);

    // R9 DMA request held until ack
    wr(4'd9, 8'h07);
    run_conv(2, 12'hFFF, 4'h0, "R9 start");
    check("R9 dma raised", 16'(dma_req), 16'h1);
    repeat (3) @(negedge clk);
    check("R9 dma held", 16'(dma_req), 16'h1);
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    check("R9 dma dropped", 16'(dma_req), 16'h0);
    check_result("R5 dma result");

    // R10 mask 0x73 keeps trigger, drops irq and dma
    wr(4'd9, 8'hF7);
    run_conv(2, 12'h800, 4'h7, "R10 start");
    check("R8 irq line 7", 16'(irq_out), 16'h80);
    wr(4'd9, 8'hF7 & 8'h73);
    check("R10 irq dropped", {7'b0, dma_req, irq_out}, 16'h000);
    check_result("R10 result");
    run_conv(2, 12'h001, 4'h8, "R10 trigger kept");
    check("R10 no irq/dma", {7'b0, dma_req, irq_out}, 16'h000);
    check_result("R10 result2");
    wr(4'd9, 8'h00);
    n0 = nstart;
    pulse_pacer(); pulse_ext();
    repeat (2) @(negedge clk);
    check("R10 stopped", 16'(nstart - n0), 16'd0);

    // R8 line 1 selected: no line raised
    wr(4'd9, 8'h93);
    run_conv(2, 12'h321, 4'h2, "R8 start");
    check("R8 line 1 none", 16'(irq_out), 16'h00);
    check_result("R5 final result");

    summary();
  end
endmodule